// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block is a parallel register port for a host processor, built to sit beside a line-interface core. Four control pins and an address and data bus give access to a small file of byte-wide registers. A static style input picks between two host timing conventions. The first has separate active-low read and write strobes. The second has one active-low data strobe together with a direction line. In both conventions an address strobe captures the address on its falling edge, and an active-low chip select gates every access.

A mode input can set the block to hardware mode instead. In that mode the four control pins no longer act as a bus. They are sampled as static equalizer-select bits and brought out on a 4-bit bus, and any bus activity on them is ignored. All pins are asynchronous to the core clock. They pass through two flip-flop stages before they are used, and strobe edges are found on the synchronised copies.

Top module: `dual_host_port`

## Requirements
- R1: After reset, with `modeSel` low, `dataOe` is 0, `eqCtrl` is 0 and every register reads 0x00.
- R2: With `modeSel` high (hardware mode), `eqCtrl` bit 0 follows `wrRwN`, bit 1 follows `rdDsN`, bit 2 follows `aleAs` and bit 3 follows `csN`. A change on a pin made between clock edges appears on `eqCtrl` after exactly the second following rising edge, and not after the first. With `modeSel` low, `eqCtrl` is 0.
- R3: In host mode, a falling edge on `aleAs` captures `addrIn` into the address register. Every later read and write uses that address until the next falling edge.
- R4: With `busStyle` 0 (separate strobes), a low pulse on `wrRwN` while `csN` is low writes `dataIn` to the addressed register when the write strobe returns high. One pulse gives exactly one write.
- R5: With `busStyle` 0, while `rdDsN` and `csN` are both low, `dataOe` is 1 and `dataOut` carries the addressed register.
- R6: With `busStyle` 1 (data strobe), `rdDsN` low while `csN` is low marks an access. `wrRwN` high makes it a read, driven as in R5. `wrRwN` low makes it a write, which is committed when `rdDsN` returns high.
- R7: While `csN` is high, strobe activity writes nothing and `dataOe` stays 0.
- R8: With `modeSel` high, strobe activity writes no register and `dataOe` stays 0.
- R9: `busStyle` is sampled only while `csN` is high. A change of `busStyle` during a chip-select-low access has no effect until `csN` returns high.
- R10: When an address-strobe falling edge and the end of a write access are detected in the same clock cycle, the write goes to the previously latched address, and the new address applies from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| modeSel | input | 1 | 1 = hardware (pin-strapped) mode, 0 = host mode |
| busStyle | input | 1 | 0 = separate read/write strobes, 1 = data strobe with direction line |
| wrRwN | input | 1 | Write strobe (style 0) or direction, 1 = read (style 1); equalizer bit 0 in hardware mode |
| rdDsN | input | 1 | Read strobe (style 0) or data strobe (style 1); equalizer bit 1 in hardware mode |
| aleAs | input | 1 | Address strobe, falling edge captures address; equalizer bit 2 in hardware mode |
| csN | input | 1 | Active-low chip select; equalizer bit 3 in hardware mode |
| addrIn | input | ADDR_W | Register address |
| dataIn | input | DATA_W | Write data from the host |
| dataOut | output | DATA_W | Read data toward the host |
| dataOe | output | 1 | Read-data output enable; 0 means the host bus is high-impedance |
| eqCtrl | output | 4 | Synchronised equalizer-select bits (hardware mode) |

## Verification
Two events can land in the same core cycle: the synchronised falling edge of the address strobe and the end of a write access. Both update state at the same clock edge, and that state holds the address used by the write. The bench provokes the collision by releasing the write strobe and dropping the address strobe on the same clock edge. Both pins go through identical two-stage synchronisers, so the two edges are detected together. The bench judges the result by reading back both the old and the new address: the data must sit only at the address latched before the collision, and the new address must be the one in effect for the next read.

// File: rtl/dual_host_port_pkg.sv
package dual_host_port_pkg;
  // strobes from control to datapath, one cycle wide except driveRd
  typedef struct packed {
    logic latchAddr;
    logic commitWr;
    logic driveRd;
  } port_strobe_t;

  // pin vector positions (also the equalizer bit order)
  localparam int PIN_WR  = 0;
  localparam int PIN_RD  = 1;
  localparam int PIN_ALE = 2;
  localparam int PIN_CS  = 3;
  localparam int PIN_CNT = 4;
endpackage

// File: rtl/host_port_ctrl.sv
module host_port_ctrl
  import dual_host_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               modeSel,
  input  logic               busStyle,
  input  logic [PIN_CNT-1:0] pinBus,
  output port_strobe_t       strb,
  output logic [PIN_CNT-1:0] eqCtrl
);
  localparam logic [PIN_CNT-1:0] PIN_IDLE = '1;

  logic [PIN_CNT-1:0] syncChain [SYNC_STAGES];
  logic [PIN_CNT-1:0] pinNow;
  logic [PIN_CNT-1:0] pinPrev;
  logic               styleReg;
  logic               wrBusy;
  logic               hostSel;
  logic               wrLvl;
  logic               rdLvl;
  logic               accessWr;
  logic               accessRd;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncChain[i] <= PIN_IDLE;
    end else begin
      syncChain[0] <= pinBus;
      for (int i = 1; i < SYNC_STAGES; i++) syncChain[i] <= syncChain[i-1];
    end
  end

  assign pinNow = syncChain[SYNC_STAGES-1];

  // pick the timing convention only while the port is deselected
  always_ff @(posedge clk) begin
    if (rst) begin
      styleReg <= 1'b0;
      pinPrev  <= PIN_IDLE;
      wrBusy   <= 1'b0;
    end else begin
      if (pinNow[PIN_CS]) styleReg <= busStyle;
      pinPrev <= pinNow;
      wrBusy  <= accessWr;
    end
  end

  always_comb begin
    if (styleReg) begin
      wrLvl = !pinNow[PIN_RD] && !pinNow[PIN_WR];
      rdLvl = !pinNow[PIN_RD] &&  pinNow[PIN_WR];
    end else begin
      wrLvl = !pinNow[PIN_WR];
      rdLvl = !pinNow[PIN_RD];
    end
  end

  assign hostSel  = !modeSel && !pinNow[PIN_CS];
  assign accessWr = hostSel && wrLvl;
  assign accessRd = hostSel && rdLvl;

  assign strb.commitWr  = wrBusy && !accessWr;
  assign strb.latchAddr = !modeSel && pinPrev[PIN_ALE] && !pinNow[PIN_ALE];
  assign strb.driveRd   = accessRd;

  assign eqCtrl = modeSel ? pinNow : '0;
endmodule

// File: rtl/host_port_regs.sv
module host_port_regs
  import dual_host_port_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  port_strobe_t      strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regFile [DEPTH];
  logic [ADDR_W-1:0] addrReg;

  // write uses the address held before any same-cycle latch
  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
    end else begin
      if (strb.commitWr) regFile[addrReg] <= dataIn;
      if (strb.latchAddr) addrReg <= addrIn;
    end
  end

  assign dataOe  = strb.driveRd;
  assign dataOut = strb.driveRd ? regFile[addrReg] : '0;
endmodule

// File: rtl/dual_host_port.sv
module dual_host_port
  import dual_host_port_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeSel,
  input  logic              busStyle,
  input  logic              wrRwN,
  input  logic              rdDsN,
  input  logic              aleAs,
  input  logic              csN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [3:0]        eqCtrl
);
  port_strobe_t       ctrlStrb;
  logic [PIN_CNT-1:0] pinBus;

  assign pinBus = {csN, aleAs, rdDsN, wrRwN};

  host_port_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .modeSel(modeSel), .busStyle(busStyle),
    .pinBus(pinBus), .strb(ctrlStrb), .eqCtrl(eqCtrl)
  );

  host_port_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .strb(ctrlStrb), .addrIn(addrIn),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/dual_host_port_chk.sv
module dual_host_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       modeSel,
  input logic       wrRwN,
  input logic       rdDsN,
  input logic       aleAs,
  input logic       csN,
  input logic       dataOe,
  input logic [3:0] eqCtrl,
  input logic       commitWr
);
  AST_EQ_MIRRORS_PINS: assert property (@(posedge clk) disable iff (rst)
    (modeSel && $past(modeSel) && $past(modeSel, 2) && !$past(rst) && !$past(rst, 2))
      |-> (eqCtrl == $past({csN, aleAs, rdDsN, wrRwN}, 2))); // R2

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> !$past(csN, 2)); // R7

  AST_HW_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (modeSel && $past(modeSel)) |-> !commitWr); // R8

  AST_WRITE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    commitWr |=> !commitWr); // R4
endmodule

bind dual_host_port dual_host_port_chk u_chk (
  .clk(clk), .rst(rst), .modeSel(modeSel), .wrRwN(wrRwN), .rdDsN(rdDsN),
  .aleAs(aleAs), .csN(csN), .dataOe(dataOe), .eqCtrl(eqCtrl),
  .commitWr(ctrlStrb.commitWr)
);

// File: tb/dual_host_port_tb.sv
`timescale 1ns/1ps
module dual_host_port_tb;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              modeSel = 1'b0;
  logic              busStyle = 1'b0;
  logic              wrRwN = 1'b1;
  logic              rdDsN = 1'b1;
  logic              aleAs = 1'b0;
  logic              csN = 1'b1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic              dataOe;
  logic [3:0]        eqCtrl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .modeSel(modeSel), .busStyle(busStyle),
    .wrRwN(wrRwN), .rdDsN(rdDsN), .aleAs(aleAs), .csN(csN),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .eqCtrl(eqCtrl)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic latchAddr(input logic [ADDR_W-1:0] a);
    aleAs = 1'b1; addrIn = a; tick(3);
    aleAs = 1'b0; tick(3);
  endtask

  task automatic writeSep(input logic [DATA_W-1:0] d);
    dataIn = d; csN = 1'b0; tick(1);
    wrRwN = 1'b0; tick(3);
    wrRwN = 1'b1; tick(3);
    csN = 1'b1; tick(3);
  endtask

  task automatic writeDs(input logic [DATA_W-1:0] d);
    dataIn = d; wrRwN = 1'b0; csN = 1'b0; tick(1);
    rdDsN = 1'b0; tick(3);
    rdDsN = 1'b1; tick(3);
    csN = 1'b1; wrRwN = 1'b1; tick(3);
  endtask

  // read in the current style: sep uses rdDsN low, ds uses rdDsN low with wrRwN high
  task automatic readCheck(input logic [DATA_W-1:0] exp, input string req);
    wrRwN = 1'b1; csN = 1'b0; tick(1);
    rdDsN = 1'b0; tick(4);
    check(dataOe === 1'b1, req, dataOe, 1);
    check(dataOut === exp, req, dataOut, exp);
    rdDsN = 1'b1; tick(1);
    csN = 1'b1; tick(4);
    check(dataOe === 1'b0, req, dataOe, 0);
  endtask

  task automatic testReset();
    check(dataOe === 1'b0, "R1", dataOe, 0);
    check(eqCtrl === 4'h0, "R1", eqCtrl, 0);
    latchAddr(4'd7);
    readCheck(8'h00, "R1");
  endtask

  task automatic testSepAccess();
    latchAddr(4'd3); writeSep(8'hA5);
    latchAddr(4'd9); writeSep(8'h5A);
    latchAddr(4'd3); readCheck(8'hA5, "R3 R4 R5");
    latchAddr(4'd9); readCheck(8'h5A, "R3 R4 R5");
    latchAddr(4'd3); writeSep(8'h11);
    readCheck(8'h11, "R4");
  endtask

  task automatic testDsAccess();
    busStyle = 1'b1; tick(4);
    latchAddr(4'd12); writeDs(8'hC3);
    latchAddr(4'd1);  writeDs(8'h3C);
    latchAddr(4'd12); readCheck(8'hC3, "R6");
    latchAddr(4'd1);  readCheck(8'h3C, "R6");
    busStyle = 1'b0; tick(4);
  endtask

  task automatic testCsGate();
    latchAddr(4'd3);
    dataIn = 8'hEE; wrRwN = 1'b0; tick(4); wrRwN = 1'b1; tick(4);
    rdDsN = 1'b0; tick(4);
    check(dataOe === 1'b0, "R7", dataOe, 0);
    rdDsN = 1'b1; tick(3);
    readCheck(8'h11, "R7");
  endtask

  task automatic testHwMode();
    modeSel = 1'b1;
    wrRwN = 1'b0; rdDsN = 1'b0; aleAs = 1'b0; csN = 1'b0; tick(3);
    // pins {cs,ale,rd,wr} = 1010
    wrRwN = 1'b0; rdDsN = 1'b1; aleAs = 1'b0; csN = 1'b1;
    tick(1);
    check(eqCtrl === 4'h0, "R2", eqCtrl, 0);
    tick(1);
    check(eqCtrl === 4'hA, "R2", eqCtrl, 4'hA);
    wrRwN = 1'b1; rdDsN = 1'b0; aleAs = 1'b1; csN = 1'b0; tick(2);
    check(eqCtrl === 4'h5, "R2", eqCtrl, 4'h5);
    // bus activity in hardware mode: read strobe and write pulse
    dataIn = 8'h99; wrRwN = 1'b0; tick(3);
    check(dataOe === 1'b0, "R8", dataOe, 0);
    wrRwN = 1'b1; tick(3);
    wrRwN = 1'b1; rdDsN = 1'b1; aleAs = 1'b0; csN = 1'b1; tick(3);
    modeSel = 1'b0; tick(3);
    check(eqCtrl === 4'h0, "R2", eqCtrl, 0);
    latchAddr(4'd3); readCheck(8'h11, "R8");
  endtask

  task automatic testStyleHold();
    latchAddr(4'd6);
    dataIn = 8'h3C; csN = 1'b0; tick(3);
    busStyle = 1'b1; tick(3);
    wrRwN = 1'b0; tick(3);   // separate-style write strobe, ds stays high
    wrRwN = 1'b1; tick(3);
    csN = 1'b1; tick(4);     // style 1 now taken
    readCheck(8'h3C, "R9");
    dataIn = 8'h42; writeDs(8'h42);
    readCheck(8'h42, "R9");
    busStyle = 1'b0; tick(4);
  endtask

  task automatic testCollision();
    latchAddr(4'd2);
    aleAs = 1'b1; addrIn = 4'd5; tick(3);
    dataIn = 8'h77; csN = 1'b0; tick(1);
    wrRwN = 1'b0; tick(3);
    wrRwN = 1'b1; aleAs = 1'b0; tick(3);   // same-cycle edges
    csN = 1'b1; tick(3);
    readCheck(8'h00, "R10");                // current address is 5
    latchAddr(4'd2);
    readCheck(8'h77, "R10");
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(4);
    testReset();
    testSepAccess();
    testDsAccess();
    testCsGate();
    testHwMode();
    testStyleHold();
    testCollision();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule